// File: doc/BRIEF.md
# Software-Strobed Three-Wire Serial Shifter

This block is a byte-wide serial master for a small register bus. Its serial clock has no rate generator. Each bus write that carries the toggle bit inverts the clock pin once, so software makes one full clock pulse with two writes. On the sampling edge of a pulse the shift register takes in the serial input at its low end. On the opposite edge the serial output takes the new top bit. Data moves most significant bit first, so after eight pulses the data register holds the byte received from the far end.

A small counter advances on every clock edge. Sixteen edges make one byte. When the counter wraps from its top value to zero, an overflow flag is set, and an interrupt request follows the flag if it is enabled. While the flag is set, the clock pin still toggles, but the shift register and the counter hold their values until software clears the flag. A write to the status register clears the flag and also loads the counter.

Three registers sit on the bus: data at address 0, status at address 1 and control at address 2. In the status register, bit 7 is the flag and bits 3:0 are the counter. In the control register, bit 0 enables the interrupt, bit 1 selects three-wire operation, bit 2 makes the toggle strobe the clock for shifting and counting, bit 3 selects the sampling edge, and bit 6 is the write-only toggle strobe.

Top module: `sws_strobe_shifter`

## Requirements
- R1: Every write to address 2 with bit 6 set inverts the clock pin once. This holds in every mode and whether or not the flag is set.
- R2: When the block is active and the flag is clear, each clock edge adds one to the counter. Status bits 3:0 read back the counter.
- R3: With control bit 3 at 0 (mode 0), the serial input is sampled on the rising clock edge, the serial output changes on the falling edge, and data moves MSB first. Right after a data write, the serial output equals bit 7 of the written value.
- R4: With control bit 3 at 1 (mode 1), the serial output changes on the rising edge and the serial input is sampled on the falling edge. After eight pulses, the byte sent and the byte received are both correct.
- R5: The 16th edge performs its own shift and wraps the counter to 0, and in that same write it sets the flag (status bit 7). The interrupt output equals the flag ANDed with control bit 0.
- R6: A status write with bit 7 at 1 clears the flag. Every status write loads bits 3:0 into the counter. A status write with bit 7 at 0 leaves the flag unchanged.
- R7: While the flag is set, strobes still toggle the clock pin, but the data register, the serial output and the counter do not change.
- R8: Unless control bits 1 and 2 are both 1, a strobe toggles the clock pin and does nothing else.
- R9: Control reads return bits 3:0 as written. Bit 6 and every other bit read as 0.
- R10: After reset, the clock pin is low, the counter and the flag are 0, the data and control registers are 0, and the interrupt is low.
- R11: When a control write both changes the configuration and carries the strobe, the edge it creates follows the newly written configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 2 | Register select: 0 data, 1 status, 2 control |
| bus_wr_i | input | 1 | Write enable for the selected register |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data of the selected register (combinational) |
| sclk_o | output | 1 | Serial clock pin |
| sdo_o | output | 1 | Serial data out |
| sdi_i | input | 1 | Serial data in |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
Two pairs of functions can land on the same bus write. The first pair is the last shift of a byte and the setting of the flag on counter wrap. The bench provokes it with the 16th strobe of every transfer and judges it by reading back the full received byte, a zero count and a set flag together. The second pair is a configuration change and a strobe. The bench sends a single control write that turns the block active and strobes at once, then expects the counter to have advanced by one.

// File: rtl/sws_pkg.sv
package sws_pkg;
    localparam int unsigned ADDR_W = 2;

    localparam logic [ADDR_W-1:0] REG_DATA = 2'd0;
    localparam logic [ADDR_W-1:0] REG_STAT = 2'd1;
    localparam logic [ADDR_W-1:0] REG_CTRL = 2'd2;

    localparam int unsigned CTL_IRQ_EN    = 0;
    localparam int unsigned CTL_WIRE3     = 1;
    localparam int unsigned CTL_STRB_CLK  = 2;
    localparam int unsigned CTL_FALL_SAMP = 3;
    localparam int unsigned CTL_TOGGLE    = 6;

    typedef struct packed {
        logic fall_samp;
        logic strb_clk;
        logic wire3;
        logic irq_en;
    } ctrl_t;
endpackage

// File: rtl/sws_edge_counter.sv
module sws_edge_counter #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             step_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.cnt = load_val_i;
        end else if (step_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o  = st_q.cnt;
    assign wrap_o = step_i && !load_i && (st_q.cnt == CNT_TOP);

    AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && !load_i) |=> (cnt_o == CNT_W'($past(cnt_o) + 1'b1))); // R2

    AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!step_i && !load_i) |=> $stable(cnt_o)); // R2
endmodule

// File: rtl/sws_shift_core.sv
module sws_shift_core #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_val_i,
    input  logic              sample_i,
    input  logic              drive_i,
    input  logic              sdi_i,
    output logic [DATA_W-1:0] data_o,
    output logic              sdo_o
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              out_bit;
    } shift_state_t;

    shift_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.data    = load_val_i;
            st_d.out_bit = load_val_i[DATA_W-1];
        end else begin
            if (sample_i) begin
                st_d.data = {st_q.data[DATA_W-2:0], sdi_i};
            end
            if (drive_i) begin
                st_d.out_bit = st_q.data[DATA_W-1];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o = st_q.data;
    assign sdo_o  = st_q.out_bit;

    AST_SAMPLE_LSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sample_i && !load_i) |=> (data_o[0] == $past(sdi_i))); // R3

    AST_LOAD_DRIVES_MSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> (sdo_o == $past(load_val_i[DATA_W-1]))); // R3
endmodule

// File: rtl/sws_strobe_shifter.sv
module sws_strobe_shifter
    import sws_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              sclk_o,
    output logic              sdo_o,
    input  logic              sdi_i,
    output logic              irq_o
);
    localparam int unsigned CNT_W = $clog2(2 * DATA_W);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    typedef struct packed {
        ctrl_t ctrl;
        logic  sclk;
        logic  flag;
    } top_state_t;

    top_state_t        st_d, st_q;
    ctrl_t             cfg_eff;
    logic              wr_data, wr_stat, wr_ctrl, strobe;
    logic              edge_ev, rising, sample_ev, drive_ev;
    logic              cnt_wrap;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] data_q;

    always_comb begin
        wr_data = bus_wr_i && (bus_addr_i == REG_DATA);
        wr_stat = bus_wr_i && (bus_addr_i == REG_STAT);
        wr_ctrl = bus_wr_i && (bus_addr_i == REG_CTRL);
        strobe  = wr_ctrl && bus_wdata_i[CTL_TOGGLE];

        cfg_eff = st_q.ctrl;
        if (wr_ctrl) begin
            cfg_eff.irq_en    = bus_wdata_i[CTL_IRQ_EN];
            cfg_eff.wire3     = bus_wdata_i[CTL_WIRE3];
            cfg_eff.strb_clk  = bus_wdata_i[CTL_STRB_CLK];
            cfg_eff.fall_samp = bus_wdata_i[CTL_FALL_SAMP];
        end

        rising    = !st_q.sclk;
        edge_ev   = strobe && cfg_eff.wire3 && cfg_eff.strb_clk && !st_q.flag;
        sample_ev = edge_ev && (rising != cfg_eff.fall_samp);
        drive_ev  = edge_ev && (rising == cfg_eff.fall_samp);

        st_d      = st_q;
        st_d.ctrl = cfg_eff;
        st_d.sclk = st_q.sclk ^ strobe;
        if (cnt_wrap) begin
            st_d.flag = 1'b1;
        end else if (wr_stat && bus_wdata_i[DATA_W-1]) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    sws_edge_counter #(
        .CNT_W(CNT_W)
    ) cnt_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .load_i    (wr_stat),
        .load_val_i(bus_wdata_i[CNT_W-1:0]),
        .step_i    (edge_ev),
        .cnt_o     (cnt_q),
        .wrap_o    (cnt_wrap)
    );

    sws_shift_core #(
        .DATA_W(DATA_W)
    ) shift_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .load_i    (wr_data),
        .load_val_i(bus_wdata_i),
        .sample_i  (sample_ev),
        .drive_i   (drive_ev),
        .sdi_i     (sdi_i),
        .data_o    (data_q),
        .sdo_o     (sdo_o)
    );

    always_comb begin
        bus_rdata_o = '0;
        unique case (bus_addr_i)
            REG_DATA: bus_rdata_o = data_q;
            REG_STAT: begin
                bus_rdata_o[DATA_W-1]  = st_q.flag;
                bus_rdata_o[CNT_W-1:0] = cnt_q;
            end
            REG_CTRL: begin
                bus_rdata_o[CTL_IRQ_EN]    = st_q.ctrl.irq_en;
                bus_rdata_o[CTL_WIRE3]     = st_q.ctrl.wire3;
                bus_rdata_o[CTL_STRB_CLK]  = st_q.ctrl.strb_clk;
                bus_rdata_o[CTL_FALL_SAMP] = st_q.ctrl.fall_samp;
            end
            default: bus_rdata_o = '0;
        endcase
    end

    assign sclk_o = st_q.sclk;
    assign irq_o  = st_q.flag && st_q.ctrl.irq_en;

    AST_STROBE_TOGGLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        strobe |=> (sclk_o != $past(sclk_o))); // R1

    AST_FLAG_ON_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_q.flag) |-> ($past(edge_ev) && ($past(cnt_q) == CNT_TOP))); // R5

    AST_FROZEN_WHEN_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.flag && !wr_data && !wr_stat) |=> ($stable(data_q) && $stable(cnt_q) && $stable(sdo_o))); // R7
endmodule

// File: tb/sws_strobe_shifter_tb.sv
module sws_strobe_shifter_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = 2'd0;
    logic       wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       sclk, sdo, irq;
    logic       sdi = 1'b0;
    int         total = 0;
    int         bad = 0;
    bit         finished = 1'b0;

    always #5 clk = ~clk;

    sws_strobe_shifter dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .bus_addr_i (addr),
        .bus_wr_i   (wr),
        .bus_wdata_i(wdata),
        .bus_rdata_o(rdata),
        .sclk_o     (sclk),
        .sdo_o      (sdo),
        .sdi_i      (sdi),
        .irq_o      (irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd_reg(2'd0, v); chk("R10 data", v, 8'h00);
        rd_reg(2'd1, v); chk("R10 status", v, 8'h00);
        rd_reg(2'd2, v); chk("R10 ctrl", v, 8'h00);
        chk("R10 sclk", {7'd0, sclk}, 8'h00);
        chk("R10 irq", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_inactive();
        logic [7:0] v;
        wr_reg(2'd2, 8'h01);
        wr_reg(2'd0, 8'h5A);
        wr_reg(2'd1, 8'h80);
        wr_reg(2'd2, 8'h41);
        chk("R8 sclk toggles", {7'd0, sclk}, 8'h01);
        wr_reg(2'd2, 8'h43);
        chk("R8 sclk toggles again", {7'd0, sclk}, 8'h00);
        rd_reg(2'd1, v); chk("R8 no count", v, 8'h00);
        rd_reg(2'd0, v); chk("R8 no shift", v, 8'h5A);
    endtask

    task automatic t_count();
        logic [7:0] v;
        wr_reg(2'd2, 8'h07);
        wr_reg(2'd1, 8'h80);
        for (int k = 1; k <= 3; k++) begin
            wr_reg(2'd2, 8'h47);
            chk("R1 sclk level", {7'd0, sclk}, {7'd0, logic'(k % 2)});
            rd_reg(2'd1, v); chk("R2 count", v, 8'(k));
        end
        wr_reg(2'd2, 8'h47);
        chk("R1 sclk back low", {7'd0, sclk}, 8'h00);
    endtask

    task automatic t_ctrl_read();
        logic [7:0] v;
        wr_reg(2'd2, 8'hFF);
        rd_reg(2'd2, v); chk("R9 ctrl readback", v, 8'h0F);
        wr_reg(2'd2, 8'h4F);
        chk("R9 sclk restored", {7'd0, sclk}, 8'h00);
    endtask

    task automatic t_same_cycle();
        logic [7:0] v;
        wr_reg(2'd2, 8'h00);
        wr_reg(2'd1, 8'h80);
        wr_reg(2'd2, 8'h46);
        rd_reg(2'd1, v); chk("R11 new config counts", v, 8'h01);
        wr_reg(2'd2, 8'h40);
        rd_reg(2'd1, v); chk("R11 inactive config no count", v, 8'h01);
        chk("R11 sclk low", {7'd0, sclk}, 8'h00);
    endtask

    task automatic t_xfer(input bit mode1, input bit ie, input logic [7:0] tx, input logic [7:0] rx);
        logic [7:0] v, got;
        logic [7:0] cfg;
        string      rq;
        rq  = mode1 ? "R4" : "R3";
        cfg = {4'b0000, mode1, 2'b11, ie};
        got = 8'h00;
        wr_reg(2'd2, cfg);
        wr_reg(2'd1, 8'h80);
        wr_reg(2'd0, tx);
        chk({rq, " sdo after load"}, {7'd0, sdo}, {7'd0, tx[7]});
        for (int i = 7; i >= 0; i--) begin
            sdi = rx[i];
            if (!mode1) got[i] = sdo;
            wr_reg(2'd2, cfg | 8'h40);
            if (mode1) got[i] = sdo;
            wr_reg(2'd2, cfg | 8'h40);
            if (i == 4) begin
                rd_reg(2'd1, v); chk({rq, " mid count"}, v, 8'h08);
            end
        end
        chk({rq, " bits sent"}, got, tx);
        rd_reg(2'd0, v); chk({rq, " byte received"}, v, rx);
        rd_reg(2'd1, v); chk("R5 flag set count zero", v, 8'h80);
        chk("R5 irq", {7'd0, irq}, {7'd0, ie});
        chk({rq, " sclk idle"}, {7'd0, sclk}, 8'h00);
    endtask

    task automatic t_frozen(input logic [7:0] rx);
        logic [7:0] v;
        logic       d0;
        d0 = sdo;
        sdi = ~sdi;
        wr_reg(2'd2, 8'h47);
        chk("R7 sclk still toggles", {7'd0, sclk}, 8'h01);
        wr_reg(2'd2, 8'h47);
        chk("R7 sclk still toggles back", {7'd0, sclk}, 8'h00);
        rd_reg(2'd0, v); chk("R7 data held", v, rx);
        rd_reg(2'd1, v); chk("R7 count held", v, 8'h80);
        chk("R7 sdo held", {7'd0, sdo}, {7'd0, d0});
    endtask

    task automatic t_load();
        logic [7:0] v;
        wr_reg(2'd1, 8'h05);
        rd_reg(2'd1, v); chk("R6 flag kept, count loaded", v, 8'h85);
        wr_reg(2'd2, 8'h07);
        wr_reg(2'd1, 8'h8C);
        rd_reg(2'd1, v); chk("R6 flag cleared, count 12", v, 8'h0C);
        chk("R6 irq low", {7'd0, irq}, 8'h00);
        for (int k = 0; k < 3; k++) wr_reg(2'd2, 8'h47);
        rd_reg(2'd1, v); chk("R6 no flag before wrap", v, 8'h0F);
        wr_reg(2'd2, 8'h47);
        rd_reg(2'd1, v); chk("R5 flag on wrap from loaded count", v, 8'h80);
        chk("R5 irq after wrap", {7'd0, irq}, 8'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_inactive();
        t_count();
        t_ctrl_read();
        t_same_cycle();
        t_xfer(1'b0, 1'b1, 8'hA5, 8'h3C);
        t_frozen(8'h3C);
        t_xfer(1'b1, 1'b1, 8'h96, 8'hE1);
        t_xfer(1'b0, 1'b0, 8'h01, 8'h80);
        t_load();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule